// File: doc/BRIEF.md
# Serial Port Register File with Interrupt Identification

This block is the byte-wide programming interface of a 16550-style serial port. A host reaches eight byte registers through one bus port with separate read and write strobes. The register index is the bus address shifted right by a configurable stride, so the registers can sit on byte, half-word or word boundaries. The block holds the baud divisor, interrupt enables, line control, modem control, FIFO control and a scratch byte. It produces the interrupt identification byte and the interrupt request line. Real FIFOs and the serial shift engines sit outside it.

Data written at index 0 leaves on one of two push strobes. The transmit push feeds the transmitter, and the loopback push feeds the receive path when modem-control loopback is on. Received bytes come in through an availability flag and a byte input. A data read pops the byte.

The transmit-ready condition is a two-state machine. `THR_QUIET` means nothing is reported, and `THR_RAISED` means the transmit-ready cause is latched. The transition QUIET to RAISED is taken on any data write, or on an interrupt-enable write that turns the transmit enable bit from 0 to 1. The transition RAISED to QUIET is taken when the identification register is read while transmit-ready is the cause being reported. Setting wins over clearing in the same cycle. Every other case holds the state.

Top module: `uart_regbank`

## Requirements
- R1: After reset: line control reads 0x03 (8 data bits, no parity, 1 stop bit), the divisor reads 12, and interrupt enable, modem control, FIFO control and scratch read 0. The identification register reads 0x01 and `irq` is low.
- R2: While line-control bit 7 is set, index 0 reads and writes the divisor low byte and index 1 the divisor high byte. Such accesses push no data and leave the interrupt-enable register untouched.
- R3: The register index is `bus_addr >> STRIDE_SHIFT`, and the low address bits are ignored. An index of 8 or more changes nothing, and a read of it returns 0.
- R4: A read of index 2 returns the identification byte. A write to index 2 loads the FIFO control. Identification bits 7:6 equal FIFO-control bits 1:0, and bits 5:4 read 0.
- R5: A cause is pending when (enable bit 0 and `rx_avail`) or (enable bit 1 and transmit-ready raised). Identification bit 0 is 0 while a cause is pending and 1 otherwise. Bits 3:1 read 010 for receive and 001 for transmit.
- R6: When both causes are pending, the identification code reports receive.
- R7: `irq` is high exactly when a cause is pending and modem-control bit 3 is set.
- R8: An interrupt-enable write that takes bit 1 from 0 to 1 raises transmit-ready. A write with bit 1 already set does not raise it.
- R9: Reading the identification register while transmit is the reported cause clears transmit-ready. The read does not clear it while receive is the reported cause.
- R10: A data write pulses `tx_push` with the byte on `tx_byte`. When modem-control bit 4 (loopback) is set, it pulses `lb_push` instead. Both kinds of data write raise transmit-ready.
- R11: Line status reads 0x60 with bit 0 equal to `rx_avail`. Modem status reads 0xB0. Writes to either have no effect.
- R12: A data read returns `rx_byte` when `rx_avail` is high and 0 otherwise. It pulses `rx_pop` only when a byte is available.
- R13: Read data is registered: it changes on the clock edge that samples `bus_rd` and holds while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_avail | input | 1 | A received byte is available |
| rx_byte | input | 8 | Received byte |
| rx_pop | output | 1 | Received byte consumed |
| tx_push | output | 1 | Byte sent to the transmitter |
| lb_push | output | 1 | Byte looped back to the receive side |
| tx_byte | output | 8 | Byte carried by either push |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of the two enable bits, receive availability, transmit-ready state and the interrupt gate bit. It checks `irq`, the identification code and the state left after the read that may clear transmit-ready. A design that ranks transmit above receive, or clears transmit-ready while receive is reported, fails the follow-up read. The bench walks all sixteen indices at reset and after out-of-range writes, which exposes a stride or range decode that aliases index 8 onto 0. It also re-writes the transmit enable bit when it is already set, which exposes edge detection done on level rather than on the 0-to-1 change. Divisor-mode accesses are checked for stray pushes or interrupt-enable corruption.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    localparam int NUM_REGS  = 8;
    localparam int REG_IDX_W = 3;

    localparam logic [2:0] IDX_DATA = 3'd0;
    localparam logic [2:0] IDX_IER  = 3'd1;
    localparam logic [2:0] IDX_IID  = 3'd2;
    localparam logic [2:0] IDX_LCR  = 3'd3;
    localparam logic [2:0] IDX_MCR  = 3'd4;
    localparam logic [2:0] IDX_LST  = 3'd5;
    localparam logic [2:0] IDX_MST  = 3'd6;
    localparam logic [2:0] IDX_SCR  = 3'd7;

    localparam int LCR_DIV_BIT  = 7;
    localparam int MCR_GATE_BIT = 3;
    localparam int MCR_LOOP_BIT = 4;
    localparam int EN_RX_BIT    = 0;
    localparam int EN_TX_BIT    = 1;

    localparam logic [7:0] LCR_AT_RESET = 8'h03;
    localparam logic [7:0] LST_FIXED    = 8'h60;
    localparam logic [7:0] MST_FIXED    = 8'hB0;

    localparam logic [2:0] CODE_RX   = 3'b010;
    localparam logic [2:0] CODE_TX   = 3'b001;
    localparam logic [2:0] CODE_NONE = 3'b000;

    typedef enum logic [0:0] {
        THR_QUIET  = 1'b0,
        THR_RAISED = 1'b1
    } thr_state_e;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode #(
    parameter int ADDR_W       = 6,
    parameter int STRIDE_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        idx,
    output logic              in_range,
    output logic [7:0]        sel
);
    localparam int IDX_W = ADDR_W - STRIDE_SHIFT;

    logic [IDX_W-1:0] full_idx;
    assign full_idx = addr[ADDR_W-1:STRIDE_SHIFT];
    assign idx      = full_idx[2:0];

    generate
        if (IDX_W > 3) begin : g_wide
            assign in_range = ~|full_idx[IDX_W-1:3];
        end else begin : g_narrow
            assign in_range = 1'b1;
        end
    endgenerate

    generate
        for (genvar g = 0; g < 8; g++) begin : g_sel
            assign sel[g] = in_range && (idx == 3'(g));
        end
    endgenerate
endmodule

// File: rtl/uart_rf_thre_fsm.sv
module uart_rf_thre_fsm
    import uart_rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic raised
);
    thr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= THR_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THR_QUIET:  if (set_evt) state_d = THR_RAISED;
            THR_RAISED: if (clr_evt && !set_evt) state_d = THR_QUIET;
            default:    state_d = THR_QUIET;
        endcase
    end

    assign raised = (state_q == THR_RAISED);

    // R8 / R10: a raise event is visible on the next cycle
    p_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> raised);
    // R9: a clear without a competing raise drops the condition
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !raised);
endmodule

// File: rtl/uart_rf_intc.sv
module uart_rf_intc
    import uart_rf_pkg::*;
#(
    parameter bit FIFO_MIRROR = 1'b1
) (
    input  logic [1:0] en,
    input  logic       rx_avail,
    input  logic       thr_raised,
    input  logic       gate,
    input  logic [1:0] fifo_lo,
    output logic [7:0] iid,
    output logic       tx_cause,
    output logic       irq
);
    logic rx_hit, tx_hit, pending;
    logic [2:0] code;
    logic [1:0] top_bits;

    assign rx_hit   = en[EN_RX_BIT] && rx_avail;
    assign tx_hit   = en[EN_TX_BIT] && thr_raised;
    assign pending  = rx_hit || tx_hit;
    assign tx_cause = tx_hit && !rx_hit;

    always_comb begin
        if (rx_hit)      code = CODE_RX;
        else if (tx_hit) code = CODE_TX;
        else             code = CODE_NONE;
    end

    generate
        if (FIFO_MIRROR) begin : g_mirror
            assign top_bits = fifo_lo;
        end else begin : g_plain
            assign top_bits = 2'b00;
        end
    endgenerate

    assign iid = {top_bits, 2'b00, code, ~pending};
    assign irq = pending && gate;
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rf_pkg::*;
#(
    parameter int          ADDR_W       = 6,
    parameter int          STRIDE_SHIFT = 2,
    parameter bit          FIFO_MIRROR  = 1'b1,
    parameter logic [15:0] DIV_AT_RESET = 16'd12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_avail,
    input  logic [7:0]        rx_byte,
    output logic              rx_pop,
    output logic              tx_push,
    output logic              lb_push,
    output logic [7:0]        tx_byte,
    output logic              irq
);
    logic [2:0]  idx;
    logic        in_range;
    logic [7:0]  sel;
    logic [7:0]  ier_q, lcr_q, mcr_q, scr_q, rdata_q, rd_mux;
    logic [1:0]  fcr_q;
    logic [15:0] div_q;
    logic        div_mode, wr_data, ier_rise, thr_raised, tx_cause;
    logic [7:0]  iid;

    uart_rf_decode #(.ADDR_W(ADDR_W), .STRIDE_SHIFT(STRIDE_SHIFT)) u_decode (
        .addr(bus_addr), .idx(idx), .in_range(in_range), .sel(sel));

    assign div_mode = lcr_q[LCR_DIV_BIT];
    assign wr_data  = bus_wr && sel[IDX_DATA] && !div_mode;
    assign ier_rise = bus_wr && sel[IDX_IER] && !div_mode
                      && !ier_q[EN_TX_BIT] && bus_wdata[EN_TX_BIT];

    uart_rf_thre_fsm u_thre (
        .clk(clk), .rst_n(rst_n),
        .set_evt(wr_data || ier_rise),
        .clr_evt(bus_rd && sel[IDX_IID] && tx_cause),
        .raised(thr_raised));

    uart_rf_intc #(.FIFO_MIRROR(FIFO_MIRROR)) u_intc (
        .en(ier_q[1:0]), .rx_avail(rx_avail), .thr_raised(thr_raised),
        .gate(mcr_q[MCR_GATE_BIT]), .fifo_lo(fcr_q),
        .iid(iid), .tx_cause(tx_cause), .irq(irq));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q <= 8'h00;
            lcr_q <= LCR_AT_RESET;
            mcr_q <= 8'h00;
            scr_q <= 8'h00;
            fcr_q <= 2'b00;
            div_q <= DIV_AT_RESET;
        end else if (bus_wr && in_range) begin
            unique case (idx)
                IDX_DATA: if (div_mode) div_q[7:0]  <= bus_wdata;
                IDX_IER:  if (div_mode) div_q[15:8] <= bus_wdata;
                          else          ier_q       <= bus_wdata;
                IDX_IID:  fcr_q <= bus_wdata[1:0];
                IDX_LCR:  lcr_q <= bus_wdata;
                IDX_MCR:  mcr_q <= bus_wdata;
                IDX_LST, IDX_MST: ;
                IDX_SCR:  scr_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = 8'h00;
        if (in_range) begin
            unique case (idx)
                IDX_DATA: rd_mux = div_mode ? div_q[7:0]
                                            : (rx_avail ? rx_byte : 8'h00);
                IDX_IER:  rd_mux = div_mode ? div_q[15:8] : ier_q;
                IDX_IID:  rd_mux = iid;
                IDX_LCR:  rd_mux = lcr_q;
                IDX_MCR:  rd_mux = mcr_q;
                IDX_LST:  rd_mux = LST_FIXED | {7'b0, rx_avail};
                IDX_MST:  rd_mux = MST_FIXED;
                IDX_SCR:  rd_mux = scr_q;
                default:  rd_mux = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= 8'h00;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign tx_push   = wr_data && !mcr_q[MCR_LOOP_BIT];
    assign lb_push   = wr_data &&  mcr_q[MCR_LOOP_BIT];
    assign tx_byte   = bus_wdata;
    assign rx_pop    = bus_rd && sel[IDX_DATA] && !div_mode && rx_avail;

    // R7: no request while the modem-control gate is off
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_q[MCR_GATE_BIT] |-> !irq);
    // R5: a raised request always shows as pending in the identification byte
    p_irq_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !iid[0]);
    // R6: enabled receive data always wins the code
    p_rx_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[EN_RX_BIT] && rx_avail) |-> (iid[3:1] == CODE_RX));
    // R10: a data byte leaves on exactly one path
    p_push_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_push && lb_push));
    // R3: out-of-range reads return zero
    p_oob_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_range) |=> (bus_rdata == 8'h00));
    // R13: read data holds without a read strobe
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // R2: divisor-mode accesses never push data
    p_div_nopush_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_mode |-> !(tx_push || lb_push || rx_pop));
endmodule

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int SHIFT      = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, rx_avail = 1'b0;
    logic [7:0] bus_wdata = 8'h00, rx_byte = 8'h00;
    logic [7:0] bus_rdata, tx_byte;
    logic rx_pop, tx_push, lb_push, irq;

    int tests = 0, fails = 0;
    int n_tx = 0, n_lb = 0, n_pop = 0;
    logic [7:0] last_tx = 8'h00, last_lb = 8'h00;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regbank #(.ADDR_W(ADDR_W), .STRIDE_SHIFT(SHIFT)) u_uart_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_pop(rx_pop),
        .tx_push(tx_push), .lb_push(lb_push), .tx_byte(tx_byte), .irq(irq));

    always @(posedge clk) begin
        if (tx_push) begin n_tx <= n_tx + 1; last_tx <= tx_byte; end
        if (lb_push) begin n_lb <= n_lb + 1; last_lb <= tx_byte; end
        if (rx_pop)  n_pop <= n_pop + 1;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] d, input int low = 0);
        @(negedge clk);
        bus_addr = ADDR_W'(idx * (1 << SHIFT) + low);
        bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [7:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(idx * (1 << SHIFT)); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] reset_val(input int idx);
        case (idx)
            2: return 8'h01;
            3: return 8'h03;
            5: return 8'h60;
            6: return 8'hB0;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R3 / R11: reset view of every index, in and out of range
        chk("R1 irq", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            chk((i < 8) ? "R1 reset read" : "R3 out-of-range read", v, reset_val(i));
        end

        // R2: divisor mode remaps indices 0 and 1
        wr(3, 8'h83);
        rd(0, v); chk("R2 div lo reset", v, 8'd12);
        rd(1, v); chk("R2 div hi reset", v, 8'h00);
        k = n_tx;
        wr(0, 8'h34); wr(1, 8'h12);
        rd(0, v); chk("R2 div lo", v, 8'h34);
        rd(1, v); chk("R2 div hi", v, 8'h12);
        chk("R2 no push", 8'(n_tx - k), 8'h00);
        wr(3, 8'h1B);
        rd(3, v); chk("R13 lcr readback", v, 8'h1B);
        rd(1, v); chk("R2 ier untouched", v, 8'h00);
        rd(2, v); chk("R2 no tx raise", v, 8'h01);
        wr(3, 8'h83);
        rd(0, v); chk("R2 div lo kept", v, 8'h34);
        wr(3, 8'h03);

        // R3: out-of-range writes ignored, low address bits ignored
        for (int i = 8; i < 16; i++) wr(i, 8'hFF);
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            chk("R3 after oob writes", v, (i < 8) ? reset_val(i) : 8'h00);
        end
        wr(7, 8'h5C, 3);
        rd(7, v); chk("R3 stride low bits", v, 8'h5C);

        // R4: FIFO-control mirror
        for (int f = 0; f < 4; f++) begin
            wr(2, 8'(f) | 8'hFC);
            rd(2, v); chk("R4 mirror", v, {2'(f), 6'b000001});
        end
        wr(2, 8'h00);

        // R11: status writes have no effect
        wr(5, 8'h00); wr(6, 8'h00);
        rx_avail = 1'b1;
        rd(5, v); chk("R11 lsr rx", v, 8'h61);
        rd(6, v); chk("R11 msr", v, 8'hB0);
        rx_avail = 1'b0;

        // R5 R6 R7 R9: full sweep of the interrupt inputs
        for (int en = 0; en < 4; en++)
            for (int rx = 0; rx < 2; rx++)
                for (int tc = 0; tc < 2; tc++)
                    for (int g = 0; g < 2; g++) begin
                        logic erx, etx;
                        rx_avail = 1'b0;
                        wr(4, 8'h00);
                        wr(1, 8'h00); wr(1, 8'h02);
                        rd(2, v);
                        if (tc != 0) wr(0, 8'h11);
                        wr(1, 8'(en));
                        wr(4, 8'(g << 3));
                        rx_avail = 1'(rx);
                        @(negedge clk);
                        erx = en[0] && (rx != 0);
                        etx = en[1] && (tc != 0);
                        chk("R7 irq", {7'b0, irq}, {7'b0, (erx || etx) && (g != 0)});
                        rd(2, v);
                        chk("R5 R6 code", v, erx ? 8'h04 : (etx ? 8'h02 : 8'h01));
                        rx_avail = 1'b0;
                        rd(2, v);
                        chk("R9 after read", v, (erx && etx) ? 8'h02 : 8'h01);
                    end

        // R8: only a 0-to-1 change of the transmit enable raises the condition
        wr(4, 8'h00); wr(1, 8'h00); wr(1, 8'h02);
        rd(2, v); chk("R8 rise", v, 8'h02);
        rd(2, v); chk("R9 cleared", v, 8'h01);
        wr(1, 8'h02);
        rd(2, v); chk("R8 no rise same", v, 8'h01);
        wr(1, 8'h03);
        rd(2, v); chk("R8 no rise set", v, 8'h01);

        // R10: normal and loopback data paths
        k = n_lb;
        wr(0, 8'hA5);
        chk("R10 tx byte", last_tx, 8'hA5);
        chk("R10 no lb", 8'(n_lb - k), 8'h00);
        rd(2, v); chk("R10 raise tx", v, 8'h02);
        wr(4, 8'h10);
        k = n_tx;
        wr(0, 8'h5A);
        chk("R10 lb byte", last_lb, 8'h5A);
        chk("R10 no tx", 8'(n_tx - k), 8'h00);
        rd(2, v); chk("R10 lb raise", v, 8'h02);
        wr(4, 8'h00); wr(1, 8'h00);

        // R12 / R13: data reads and registered hold
        rx_byte = 8'h3C; rx_avail = 1'b1; k = n_pop;
        rd(0, v); chk("R12 rx byte", v, 8'h3C);
        chk("R12 pop", 8'(n_pop - k), 8'h01);
        rx_byte = 8'hC3;
        repeat (3) @(negedge clk);
        chk("R13 hold", bus_rdata, 8'h3C);
        rx_avail = 1'b0; k = n_pop;
        rd(0, v); chk("R12 empty read", v, 8'h00);
        chk("R12 no pop", 8'(n_pop - k), 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule